// File: doc/BRIEF.md
# Hot-Drink Dispense Sequencer

This block is the sequencing core of a hot-drink dispenser. It watches two push-button inputs that have already been synchronised, one for coffee and one for tea, and runs a fixed dispense sequence for the chosen drink. The coffee route passes through a coffee stage, a milk stage and a sugar stage before it returns to idle. The tea route passes through a tea stage and then joins the same sugar stage. The milk and sugar stages each wait for a dispense-done input from their own ingredient hardware. Each also enforces a minimum number of cycles in the stage, so a done signal that is already high cannot cut the stage short.

The state register is visible on a 3-bit output. Each stage drives its own bit of a one-hot valve-enable bus. A busy lamp is lit whenever a drink is in progress. A ready lamp is lit for the single cycle in which the sugar stage hands control back to idle. An active-low power-on reset puts the block in idle. Every pin is a plain level. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `brew_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, state_o reads 0 (idle), and valve_o, busy_o and ready_o are all low.
- R2: state_o carries the stage code: idle=0, coffee=1, milk=2, sugar=3, tea=4. It changes only at a rising clock edge.
- R3: In idle with both buttons low, the state stays at 0 on every edge.
- R4: In idle with btn_coffee_i high, the next edge moves the state to coffee (1). This holds even when btn_tea_i is also high, so coffee has priority.
- R5: In idle with only btn_tea_i high, the next edge moves the state to tea (4).
- R6: Coffee lasts exactly one cycle and then goes to milk (2). Tea lasts exactly one cycle and then goes to sugar (3). Neither depends on any input.
- R7: Milk holds while milk_done_i is low. It advances to sugar at the first edge at which milk_done_i is high and the machine has spent at least MILK_MIN_CYC cycles (default 2) in milk.
- R8: Sugar holds while sugar_done_i is low. It returns to idle at the first edge at which sugar_done_i is high and at least SUGAR_MIN_CYC cycles (default 1) have passed in sugar.
- R9: valve_o is one-hot on the current stage: bit0=coffee, bit1=milk, bit2=sugar, bit3=tea. It is all zero in idle.
- R10: busy_o is high exactly when state_o is not idle.
- R11: ready_o is high only in the cycle in which the sugar stage will leave for idle at the next edge. That cycle is sugar with sugar_done_i high and the minimum dwell met.
- R12: The drink buttons have no effect outside idle. The stage sequence and state_o are the same whether the buttons are high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes at its rising edge |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| btn_coffee_i | input | 1 | Synchronised coffee selection button |
| btn_tea_i | input | 1 | Synchronised tea selection button |
| milk_done_i | input | 1 | Milk dispenser reports its portion is delivered |
| sugar_done_i | input | 1 | Sugar dispenser reports its portion is delivered |
| state_o | output | 3 | Current stage code |
| valve_o | output | 4 | One-hot ingredient solenoid/pump enables |
| busy_o | output | 1 | In-progress lamp |
| ready_o | output | 1 | Drink-ready lamp, one-cycle pulse |

## Verification
The stage code, valve_o and busy_o come from the state register. Each of them shows the effect of an input one rising edge after that input is applied. ready_o is decoded without a register from the sugar stage and sugar_done_i, so it is valid in the same cycle as the input. The bench changes inputs 2 ns after a rising edge. It checks ready_o before the next edge and checks the registered outputs 2 ns after that edge. The milk minimum dwell is counted in edges from the cycle the stage is entered.

// File: rtl/brew_pkg.sv
package brew_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_COFFEE = 3'd1,
    ST_MILK   = 3'd2,
    ST_SUGAR  = 3'd3,
    ST_TEA    = 3'd4
  } brew_state_e;

  localparam int STATE_W = 3;
  localparam int VALVE_N = 4;

  // valve bit index to stage code
  function automatic logic [STATE_W-1:0] valve_stage(input int idx);
    case (idx)
      0:       valve_stage = ST_COFFEE;
      1:       valve_stage = ST_MILK;
      2:       valve_stage = ST_SUGAR;
      default: valve_stage = ST_TEA;
    endcase
  endfunction
endpackage

// File: rtl/brew_dwell_timer.sv
module brew_dwell_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  // R7: a restart always clears the count on the next edge
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (count_o == '0));
endmodule

// File: rtl/brew_next_state.sv
module brew_next_state
  import brew_pkg::*;
#(
  parameter int MILK_MIN_CYC  = 2,
  parameter int SUGAR_MIN_CYC = 1,
  parameter int CNT_W         = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic [CNT_W-1:0]   dwell_i,
  input  logic               btn_coffee_i,
  input  logic               btn_tea_i,
  input  logic               milk_done_i,
  input  logic               sugar_done_i,
  output logic [STATE_W-1:0] state_nx_o,
  output logic               sugar_exit_o
);
  localparam logic [CNT_W-1:0] MILK_LAST  = CNT_W'(MILK_MIN_CYC - 1);
  localparam logic [CNT_W-1:0] SUGAR_LAST = CNT_W'(SUGAR_MIN_CYC - 1);

  logic milk_ok, sugar_ok;

  assign milk_ok      = milk_done_i  && (dwell_i >= MILK_LAST);
  assign sugar_ok     = sugar_done_i && (dwell_i >= SUGAR_LAST);
  assign sugar_exit_o = (state_i == ST_SUGAR) && sugar_ok;

  always_comb begin
    state_nx_o = ST_IDLE;
    case (state_i)
      ST_IDLE: begin
        if (btn_coffee_i)   state_nx_o = ST_COFFEE;
        else if (btn_tea_i) state_nx_o = ST_TEA;
        else                state_nx_o = ST_IDLE;
      end
      ST_COFFEE: state_nx_o = ST_MILK;
      ST_TEA:    state_nx_o = ST_SUGAR;
      ST_MILK:   state_nx_o = milk_ok  ? ST_SUGAR : ST_MILK;
      ST_SUGAR:  state_nx_o = sugar_ok ? ST_IDLE  : ST_SUGAR;
      default:   state_nx_o = ST_IDLE;
    endcase
  end

  // R4: coffee priority over tea from idle
  p_coffee_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE && btn_coffee_i) |-> (state_nx_o == ST_COFFEE));
  // R12: no way out of a non-idle stage into coffee or tea
  p_no_reselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_IDLE) |-> (state_nx_o != ST_COFFEE && state_nx_o != ST_TEA));
endmodule

// File: rtl/brew_output_decode.sv
module brew_output_decode
  import brew_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               sugar_exit_i,
  output logic [VALVE_N-1:0] valve_o,
  output logic               busy_o,
  output logic               ready_o
);
  for (genvar v = 0; v < VALVE_N; v++) begin : g_valve
    assign valve_o[v] = (state_i == valve_stage(v));
  end

  assign busy_o  = (state_i != ST_IDLE);
  assign ready_o = sugar_exit_i;

  // R9: never more than one ingredient path open
  p_valve_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valve_o));
  // R11: ready only while the sugar valve is open
  p_ready_in_sugar_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> valve_o[2]);
endmodule

// File: rtl/brew_sequencer.sv
module brew_sequencer
  import brew_pkg::*;
#(
  parameter int MILK_MIN_CYC  = 2,
  parameter int SUGAR_MIN_CYC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         btn_coffee_i,
  input  logic         btn_tea_i,
  input  logic         milk_done_i,
  input  logic         sugar_done_i,
  output logic [2:0]   state_o,
  output logic [3:0]   valve_o,
  output logic         busy_o,
  output logic         ready_o
);
  localparam int MAX_MIN = (MILK_MIN_CYC > SUGAR_MIN_CYC) ? MILK_MIN_CYC : SUGAR_MIN_CYC;
  localparam int CNT_W   = (MAX_MIN < 2) ? 1 : $clog2(MAX_MIN);

  logic [STATE_W-1:0] state_q, state_nx;
  logic [CNT_W-1:0]   dwell;
  logic               sugar_exit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

  brew_dwell_timer #(.CNT_W(CNT_W)) u_dwell (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (state_nx != state_q),
    .count_o   (dwell)
  );

  brew_next_state #(
    .MILK_MIN_CYC  (MILK_MIN_CYC),
    .SUGAR_MIN_CYC (SUGAR_MIN_CYC),
    .CNT_W         (CNT_W)
  ) u_next (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (state_q),
    .dwell_i      (dwell),
    .btn_coffee_i (btn_coffee_i),
    .btn_tea_i    (btn_tea_i),
    .milk_done_i  (milk_done_i),
    .sugar_done_i (sugar_done_i),
    .state_nx_o   (state_nx),
    .sugar_exit_o (sugar_exit)
  );

  brew_output_decode u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (state_q),
    .sugar_exit_i (sugar_exit),
    .valve_o      (valve_o),
    .busy_o       (busy_o),
    .ready_o      (ready_o)
  );

  assign state_o = state_q;

  // R2: only the five defined codes appear
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);
  // R3: idle with no button stays idle
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !btn_coffee_i && !btn_tea_i) |=> (state_o == 3'd0));
  // R6: coffee and tea are single-cycle stages
  p_coffee_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |=> (state_o == 3'd2));
  p_tea_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |=> (state_o == 3'd3));
  // R7: milk entered from coffee lasts at least a second cycle
  p_milk_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) == 3'd1 && MILK_MIN_CYC >= 2) |=> (state_o == 3'd2));
  // R11: a ready pulse is followed by idle and no second pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> (state_o == 3'd0 && !ready_o));
endmodule

// File: tb/brew_sequencer_bench.sv
`timescale 1ns/1ps
module brew_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_coffee = 1'b0, btn_tea = 1'b0, milk_done = 1'b0, sugar_done = 1'b0;
  logic [2:0] state;
  logic [3:0] valve;
  logic busy, ready;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  brew_sequencer u_brew_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_coffee_i (btn_coffee),
    .btn_tea_i    (btn_tea),
    .milk_done_i  (milk_done),
    .sugar_done_i (sugar_done),
    .state_o      (state),
    .valve_o      (valve),
    .busy_o       (busy),
    .ready_o      (ready)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int valve_for(input int st);
    case (st)
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic chk_stage(input int exp, input string tag);
    chk(state, exp, {tag, " state"});
    chk(valve, valve_for(exp), {"R9 valve ", tag});
    chk(busy, (exp != 0) ? 1 : 0, {"R10 busy ", tag});
  endtask

  task automatic idle_all();
    btn_coffee = 0; btn_tea = 0; milk_done = 0; sugar_done = 0;
  endtask

  task automatic t_reset();
    #3;
    chk(state, 0, "R1 state in reset");
    chk(valve, 0, "R1 valve in reset");
    chk(busy, 0, "R1 busy in reset");
    chk(ready, 0, "R1 ready in reset");
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk_stage(0, "R1 after release");
    chk(ready, 0, "R1 ready after release");
  endtask

  task automatic t_idle_hold();
    idle_all();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk_stage(0, "R3 idle hold");
    end
    milk_done = 1; sugar_done = 1;
    tick();
    chk_stage(0, "R3 idle ignores done inputs");
    chk(ready, 0, "R11 no ready in idle");
    idle_all();
  endtask

  task automatic t_coffee_route();
    idle_all();
    btn_coffee = 1;
    tick();
    chk_stage(1, "R4 coffee entered");
    btn_coffee = 0;
    tick();
    chk_stage(2, "R6 coffee to milk");
    tick(); tick();
    chk_stage(2, "R7 milk holds while done low");
    milk_done = 1;
    tick();
    chk_stage(3, "R7 milk to sugar on done");
    milk_done = 0;
    tick();
    chk_stage(3, "R8 sugar holds while done low");
    chk(ready, 0, "R11 no ready while sugar waits");
    sugar_done = 1;
    #1;
    chk(ready, 1, "R11 ready in exit cycle");
    tick();
    chk_stage(0, "R8 sugar to idle");
    chk(ready, 0, "R11 ready dropped in idle");
    idle_all();
  endtask

  task automatic t_tea_route();
    idle_all();
    btn_tea = 1;
    tick();
    chk_stage(4, "R5 tea entered");
    btn_tea = 0;
    tick();
    chk_stage(3, "R6 tea to sugar");
    sugar_done = 1;
    #1;
    chk(ready, 1, "R11 ready on first sugar cycle");
    tick();
    chk_stage(0, "R8 tea route back to idle");
    idle_all();
  endtask

  task automatic t_both_buttons();
    idle_all();
    btn_coffee = 1; btn_tea = 1;
    tick();
    chk_stage(1, "R4 coffee wins over tea");
    idle_all();
    tick();
    chk_stage(2, "R6 priority route to milk");
    milk_done = 1;
    tick(); tick();
    sugar_done = 1;
    tick();
    chk_stage(0, "R8 drain to idle");
    idle_all();
  endtask

  task automatic t_milk_min_dwell();
    idle_all();
    btn_coffee = 1;
    tick();
    btn_coffee = 0;
    milk_done = 1;
    tick();
    chk_stage(2, "R7 milk first cycle");
    tick();
    chk_stage(2, "R7 milk minimum second cycle");
    tick();
    chk_stage(3, "R7 milk leaves after minimum");
    milk_done = 0; sugar_done = 1;
    tick();
    chk_stage(0, "R8 min-one sugar exit");
    idle_all();
  endtask

  task automatic t_buttons_ignored();
    idle_all();
    btn_tea = 1;
    tick();
    chk_stage(4, "R5 tea entered");
    btn_coffee = 1;
    tick();
    chk_stage(3, "R12 buttons ignored in tea");
    tick();
    chk_stage(3, "R12 buttons ignored in sugar");
    sugar_done = 1;
    btn_coffee = 0; btn_tea = 0;
    tick();
    chk_stage(0, "R12 back to idle");
    btn_tea = 1; btn_coffee = 0; sugar_done = 0;
    tick();
    chk_stage(4, "R2 restart after drink");
    btn_tea = 0; btn_coffee = 1;
    tick();
    chk_stage(3, "R12 coffee ignored in tea");
    btn_coffee = 0; sugar_done = 1;
    tick();
    chk_stage(0, "R2 final idle");
    idle_all();
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_hold();
    t_coffee_route();
    t_tea_route();
    t_both_buttons();
    t_milk_min_dwell();
    t_buttons_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule